// File: doc/BRIEF.md
# Multi-Cycle Shift and Rotate Unit

This execution unit carries out the eight-member shift/rotate opcode group on an 8-bit or 16-bit operand. The caller presents the operand, a 3-bit operation extension, a count source select, the CL value, the immediate byte and the incoming flags. It then pulses `start`. The unit moves the operand one bit position per clock, so its latency grows with the count. When it pulses `done`, the result and the carry, overflow, sign, zero and parity flags are ready. They stay valid until the next accepted start.

The count is never reduced to five bits. Both a CL count and an immediate count use all eight bits. A count of 200 on a 16-bit logical shift therefore really steps 200 times and ends at zero. Extension 6 has no operation of its own and behaves as a left shift.

Top module: `shift_rot_unit`

## Requirements
- R1: After reset, `busy` and `done` are 0. `start` is accepted only while `busy` is 0. A `start` raised while `busy` is 1 has no effect on the operation in progress or on its result.
- R2: A count of zero makes `done` rise in the cycle after the start edge and keeps `busy` at 0. The result equals the operand, zero-extended from the low byte in 8-bit mode. All five flag outputs equal the incoming flags.
- R3: A count of N > 0 holds `busy` high for N cycles after the start edge. `done` is then high for exactly one cycle, N+1 cycles after the start edge.
- R4: With `cntSel` = 1 the count is all eight bits of `clCount`, with no masking.
- R5: With `cntSel` = 2 or 3 the count is all eight bits of `immCount`, with no masking.
- R6: With `cntSel` = 0 exactly one step is performed, whatever `clCount` and `immCount` hold.
- R7: The extension is encoded as 0 rotate left, 1 rotate right, 2 rotate left through carry, 3 rotate right through carry, 4 shift left, 5 logical shift right and 7 arithmetic shift right.
- R8: Extension 6 gives the same result and flags as extension 4 for every count.
- R9: Counts larger than the operand width keep stepping. Logical shifts end at zero, an arithmetic right shift ends with every bit equal to the sign, and rotates wrap.
- R10: For any count above zero, carry holds the last bit shifted out of the operand.
- R11: For a count of exactly one, overflow is set as follows. It is MSB(result) XOR carry for left operations. It is the XOR of the two top result bits for right operations. For any other count it equals the incoming overflow.
- R12: For shifts (extensions 4 to 7) with a count above zero, sign is the result MSB and zero is set when the result is 0. Parity is 1 when the low result byte has an even number of ones. Rotates pass the incoming sign, zero and parity through.
- R13: In 8-bit mode (`wide` = 0) the MSB is bit 7 and result bits 15:8 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| ext | input | 3 | Operation extension |
| wide | input | 1 | 1 = 16-bit operand, 0 = 8-bit |
| cntSel | input | 2 | Count source: 0 one, 1 CL, 2/3 immediate |
| clCount | input | 8 | CL register value |
| immCount | input | 8 | Immediate count byte |
| operand | input | 16 | Operand value |
| cfIn | input | 1 | Incoming carry flag |
| ofIn | input | 1 | Incoming overflow flag |
| sfIn | input | 1 | Incoming sign flag |
| zfIn | input | 1 | Incoming zero flag |
| pfIn | input | 1 | Incoming parity flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Shifted/rotated value |
| cfOut | output | 1 | Carry flag |
| ofOut | output | 1 | Overflow flag |
| sfOut | output | 1 | Sign flag |
| zfOut | output | 1 | Zero flag |
| pfOut | output | 1 | Parity flag |

## Verification
A wrong remaining-count value is visible at once in the timing. The distance from start to `done` stops matching N+1, so each operation's latency is measured against its count. A wrong accumulator or carry bit shows up only at completion, in the result or `cfOut`. That is why every operation is compared against an independent bench model. Large unmasked counts and an intruding start during busy are checked as well. A latched operation code or width that is wrong is caught by the per-extension comparisons in 8-bit and 16-bit mode, and by pass-through checks on the rotate flags.

// File: rtl/sr_pkg.sv
package sr_pkg;

  typedef enum logic [2:0] {
    OP_ROL = 3'd0,
    OP_ROR = 3'd1,
    OP_RCL = 3'd2,
    OP_RCR = 3'd3,
    OP_SHL = 3'd4,
    OP_SHR = 3'd5,
    OP_SAR = 3'd7
  } shiftOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // latch operand, op and flags
    logic zeroCnt;  // accepted operation has a count of zero
    logic oneStep;  // accepted operation has a count of one
    logic step;     // perform one bit step this cycle
  } srStrobe_t;

  function automatic shiftOp_e decodeExt(input logic [2:0] ext);
    shiftOp_e op;
    if (ext == 3'd6) op = OP_SHL;  // extension 6 aliases the left shift
    else op = shiftOp_e'(ext);
    return op;
  endfunction

endpackage

// File: rtl/sr_control.sv
module sr_control
  import sr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       cntSel,
  input  logic [CNT_W-1:0] clCount,
  input  logic [CNT_W-1:0] immCount,
  output logic             busy,
  output logic             done,
  output srStrobe_t        strobe
);

  logic [CNT_W-1:0] reqCount;
  logic [CNT_W-1:0] remain;
  logic             accept;

  always_comb begin
    unique case (cntSel)
      2'd0:    reqCount = CNT_W'(1);
      2'd1:    reqCount = clCount;
      default: reqCount = immCount;
    endcase
  end

  assign accept         = start && !busy;
  assign strobe.load    = accept;
  assign strobe.zeroCnt = accept && (reqCount == '0);
  assign strobe.oneStep = accept && (reqCount == CNT_W'(1));
  assign strobe.step    = busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        remain <= reqCount;
        busy   <= (reqCount != '0);
        done   <= (reqCount == '0);
      end else if (busy) begin
        remain <= remain - CNT_W'(1);
        if (remain == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  a_r1_busy_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  a_r2_zero_count_done: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && reqCount == '0) |=> (done && !busy));

  a_r3_done_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  a_r3_count_walks: assert property (@(posedge clk) disable iff (!rstN)
    (busy && remain > CNT_W'(1)) |=> (busy && remain == $past(remain) - CNT_W'(1)));

endmodule

// File: rtl/sr_datapath.sv
module sr_datapath
  import sr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  srStrobe_t         strobe,
  input  logic [2:0]        ext,
  input  logic              wide,
  input  logic [DATA_W-1:0] operand,
  input  logic              cfIn,
  input  logic              ofIn,
  input  logic              sfIn,
  input  logic              zfIn,
  input  logic              pfIn,
  output logic [DATA_W-1:0] result,
  output logic              cfOut,
  output logic              ofOut,
  output logic              sfOut,
  output logic              zfOut,
  output logic              pfOut
);

  localparam int HALF_W = DATA_W / 2;
  localparam int PAR_W  = 8;

  logic [DATA_W-1:0] acc, nextAcc, widthMask, shl1, shr1;
  logic              carry, nextCarry, isWide, oneStepQ, zeroQ;
  logic              ofQ, sfQ, zfQ, pfQ;
  shiftOp_e          op;
  logic              msbBit, msb2Bit, lowIn, topIn, goLeft, isShift;

  assign widthMask = isWide ? {DATA_W{1'b1}} : {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  assign msbBit    = isWide ? acc[DATA_W-1] : acc[HALF_W-1];
  assign msb2Bit   = isWide ? acc[DATA_W-2] : acc[HALF_W-2];
  assign goLeft    = (op == OP_ROL) || (op == OP_RCL) || (op == OP_SHL);
  assign isShift   = (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR);

  always_comb begin
    lowIn = 1'b0;
    topIn = 1'b0;
    unique case (op)
      OP_ROL:  lowIn = msbBit;
      OP_RCL:  lowIn = carry;
      OP_ROR:  topIn = acc[0];
      OP_RCR:  topIn = carry;
      OP_SAR:  topIn = msbBit;
      default: ;
    endcase
    shl1 = ((acc << 1) | DATA_W'(lowIn)) & widthMask;
    shr1 = acc >> 1;
    if (isWide) shr1[DATA_W-1] = topIn;
    else        shr1[HALF_W-1] = topIn;
    nextAcc   = goLeft ? shl1 : shr1;
    nextCarry = goLeft ? msbBit : acc[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc      <= '0;
      carry    <= 1'b0;
      op       <= OP_ROL;
      isWide   <= 1'b1;
      oneStepQ <= 1'b0;
      zeroQ    <= 1'b1;
      ofQ      <= 1'b0;
      sfQ      <= 1'b0;
      zfQ      <= 1'b0;
      pfQ      <= 1'b0;
    end else if (strobe.load) begin
      acc      <= wide ? operand : (operand & {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}});
      carry    <= cfIn;
      op       <= decodeExt(ext);
      isWide   <= wide;
      oneStepQ <= strobe.oneStep;
      zeroQ    <= strobe.zeroCnt;
      ofQ      <= ofIn;
      sfQ      <= sfIn;
      zfQ      <= zfIn;
      pfQ      <= pfIn;
    end else if (strobe.step) begin
      acc   <= nextAcc;
      carry <= nextCarry;
    end
  end

  assign result = acc;
  assign cfOut  = carry;
  assign ofOut  = oneStepQ ? (goLeft ? (msbBit ^ carry) : (msbBit ^ msb2Bit)) : ofQ;
  assign sfOut  = (isShift && !zeroQ) ? msbBit : sfQ;
  assign zfOut  = (isShift && !zeroQ) ? (acc == '0) : zfQ;
  assign pfOut  = (isShift && !zeroQ) ? ~^acc[PAR_W-1:0] : pfQ;

  a_r13_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    !isWide |-> (acc[DATA_W-1:HALF_W] == '0));

  a_r9_sar_keeps_sign: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load && op == OP_SAR) |=> (msbBit == $past(msbBit)));

  a_r7_rotate_keeps_ones: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load && (op == OP_ROL || op == OP_ROR))
      |=> ($countones(acc) == $past($countones(acc))));

endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
  import sr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        ext,
  input  logic              wide,
  input  logic [1:0]        cntSel,
  input  logic [CNT_W-1:0]  clCount,
  input  logic [CNT_W-1:0]  immCount,
  input  logic [DATA_W-1:0] operand,
  input  logic              cfIn,
  input  logic              ofIn,
  input  logic              sfIn,
  input  logic              zfIn,
  input  logic              pfIn,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              cfOut,
  output logic              ofOut,
  output logic              sfOut,
  output logic              zfOut,
  output logic              pfOut
);

  srStrobe_t strobe;

  sr_control #(.CNT_W(CNT_W)) u_control (
    .clk(clk), .rstN(rstN), .start(start), .cntSel(cntSel),
    .clCount(clCount), .immCount(immCount),
    .busy(busy), .done(done), .strobe(strobe)
  );

  sr_datapath #(.DATA_W(DATA_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ext(ext), .wide(wide),
    .operand(operand), .cfIn(cfIn), .ofIn(ofIn), .sfIn(sfIn),
    .zfIn(zfIn), .pfIn(pfIn), .result(result), .cfOut(cfOut),
    .ofOut(ofOut), .sfOut(sfOut), .zfOut(zfOut), .pfOut(pfOut)
  );

endmodule

// File: tb/test_shift_rot_unit.sv
module test_shift_rot_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  ext = '0;
  logic        wide = 1'b1;
  logic [1:0]  cntSel = '0;
  logic [7:0]  clCount = '0;
  logic [7:0]  immCount = '0;
  logic [15:0] operand = '0;
  logic        cfIn = 0, ofIn = 0, sfIn = 0, zfIn = 0, pfIn = 0;
  logic        busy, done, cfOut, ofOut, sfOut, zfOut, pfOut;
  logic [15:0] result;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  shift_rot_unit i_shift_rot_unit (
    .clk(clk), .rstN(rstN), .start(start), .ext(ext), .wide(wide),
    .cntSel(cntSel), .clCount(clCount), .immCount(immCount),
    .operand(operand), .cfIn(cfIn), .ofIn(ofIn), .sfIn(sfIn),
    .zfIn(zfIn), .pfIn(pfIn), .busy(busy), .done(done), .result(result),
    .cfOut(cfOut), .ofOut(ofOut), .sfOut(sfOut), .zfOut(zfOut), .pfOut(pfOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench model: returns {result[15:0], cf, of, sf, zf, pf}
  function automatic logic [20:0] model(input logic [2:0] e0, input logic wd,
      input int cnt, input logic [15:0] opnd, input logic [4:0] fin);
    int w = wd ? 16 : 8;
    int e = (e0 == 3'd6) ? 4 : int'(e0);
    logic [15:0] v = wd ? opnd : {8'h00, opnd[7:0]};
    logic c = fin[4];
    logic o = fin[3], s = fin[2], z = fin[1], p = fin[0];
    logic origTop = v[w-1];
    logic bOut, bIn;
    for (int i = 0; i < cnt; i++) begin
      if (e == 0 || e == 2 || e == 4) begin
        bOut = v[w-1];
        bIn = (e == 0) ? bOut : (e == 2) ? c : 1'b0;
        v = {v[14:0], bIn};
        if (!wd) v[15:8] = 8'h00;
      end else begin
        bOut = v[0];
        bIn = (e == 1) ? bOut : (e == 3) ? c : (e == 7) ? v[w-1] : 1'b0;
        v = v >> 1;
        v[w-1] = bIn;
      end
      c = bOut;
    end
    if (cnt == 1) begin
      case (e)
        5: o = origTop;
        7: o = 1'b0;
        1: o = v[w-1] ^ v[w-2];
        3: o = origTop ^ fin[4];
        default: o = v[w-1] ^ c;
      endcase
    end
    if (cnt != 0 && e >= 4) begin
      s = v[w-1];
      z = (v == 16'h0);
      p = ~^v[7:0];
    end
    return {v, c, o, s, z, p};
  endfunction

  // Run one operation; poke = raise start again while busy (R1)
  task automatic runOp(input logic [2:0] e, input logic wd, input logic [1:0] sel,
      input logic [7:0] cl, input logic [7:0] im, input logic [15:0] opnd,
      input logic [4:0] fin, input bit poke, input string tag);
    int cnt = (sel == 2'd0) ? 1 : (sel == 2'd1) ? int'(cl) : int'(im);
    logic [20:0] exp = model(e, wd, cnt, opnd, fin);
    int cyc;
    @(negedge clk);
    ext = e; wide = wd; cntSel = sel; clCount = cl; immCount = im; operand = opnd;
    {cfIn, ofIn, sfIn, zfIn, pfIn} = fin;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    if (cnt > 0) chk({tag, " R3 busy"}, int'(busy), 1);
    else chk({tag, " R2 idle"}, int'(busy), 0);
    while (!done && cyc < 400) begin
      if (poke && cyc == 2) begin
        start = 1'b1; operand = ~opnd; ext = e + 3'd1; immCount = 8'd0; clCount = 8'd0;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk({tag, " R3 latency"}, cyc, cnt + 1);
    chk({tag, " R7 result"}, int'(result), int'(exp[20:5]));
    chk({tag, " R10 carry"}, int'(cfOut), int'(exp[4]));
    chk({tag, " R11 overflow"}, int'(ofOut), int'(exp[3]));
    chk({tag, " R12 sign"}, int'(sfOut), int'(exp[2]));
    chk({tag, " R12 zero"}, int'(zfOut), int'(exp[1]));
    chk({tag, " R12 parity"}, int'(pfOut), int'(exp[0]));
    @(negedge clk);
    chk({tag, " R3 done pulse"}, int'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [20:0] a, b;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(done), 0);
    rstN = 1'b1;

    runOp(3'd4, 1'b1, 2'd1, 8'd0, 8'd7, 16'h8001, 5'b10101, 1'b0, "R2 zero CL");
    runOp(3'd0, 1'b0, 2'd2, 8'd3, 8'd0, 16'hABCD, 5'b01010, 1'b0, "R2 zero imm narrow");
    runOp(3'd4, 1'b1, 2'd1, 8'd200, 8'd1, 16'h1234, 5'b00000, 1'b0, "R4 R9 CL 200 shl");
    runOp(3'd7, 1'b1, 2'd2, 8'd1, 8'd255, 16'h8000, 5'b00000, 1'b0, "R5 R9 imm 255 sar");
    runOp(3'd5, 1'b0, 2'd3, 8'd0, 8'd40, 16'h00FF, 5'b00000, 1'b0, "R5 R9 imm 40 shr narrow");
    runOp(3'd0, 1'b1, 2'd2, 8'd0, 8'd17, 16'h8001, 5'b00000, 1'b0, "R9 rol wrap");
    runOp(3'd5, 1'b1, 2'd0, 8'd5, 8'd9, 16'h8001, 5'b00000, 1'b0, "R6 single shr");
    runOp(3'd4, 1'b1, 2'd0, 8'd9, 8'd4, 16'h4000, 5'b00000, 1'b0, "R6 R11 single shl");
    runOp(3'd3, 1'b0, 2'd0, 8'd0, 8'd0, 16'h0081, 5'b10000, 1'b0, "R11 R13 rcr narrow");
    runOp(3'd2, 1'b1, 2'd1, 8'd3, 8'd0, 16'hF00F, 5'b10111, 1'b0, "R12 rcl keeps flags");
    runOp(3'd4, 1'b1, 2'd2, 8'd0, 8'd6, 16'h1234, 5'b00000, 1'b1, "R1 start while busy");

    // Extension 6 versus extension 4 via the ports (R8)
    for (int k = 0; k < 6; k++) begin
      logic [15:0] v = 16'($urandom);
      logic [7:0] n = 8'($urandom % 20);
      logic [15:0] r4, r6;
      runOp(3'd4, 1'b1, 2'd2, 8'd0, n, v, 5'b00000, 1'b0, "R8 ext4");
      r4 = result; a = {result, cfOut, ofOut, sfOut, zfOut, pfOut};
      runOp(3'd6, 1'b1, 2'd2, 8'd0, n, v, 5'b00000, 1'b0, "R8 ext6");
      r6 = result; b = {result, cfOut, ofOut, sfOut, zfOut, pfOut};
      chk("R8 ext6 equals ext4", int'(b), int'(a));
      if (r4 != r6) $display("note R8 results %0h %0h", r6, r4);
    end

    for (int k = 0; k < 300; k++) begin
      logic [2:0] e = 3'($urandom);
      logic wd = 1'($urandom);
      logic [1:0] sel = 2'($urandom);
      logic [7:0] cl = ($urandom % 2) ? 8'($urandom) : 8'($urandom % 20);
      logic [7:0] im = ($urandom % 2) ? 8'($urandom) : 8'($urandom % 20);
      runOp(e, wd, sel, cl, im, 16'($urandom), 5'($urandom), 1'b0,
            wd ? "R7 random wide" : "R13 random narrow");
      if (!wd) chk("R13 upper byte", int'(result[15:8]), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule